// File: doc/BRIEF.md
# Video Output Port Clock Gater

This block produces the output-side timing of a synchronous video port from one fast system clock. It creates a transfer-clock enable at twice the pixel rate and a pixel strobe at the pixel rate. It also creates a data-valid flag that marks the single uninterrupted burst of active pixels in each line, and a word strobe that marks every transfer of data, in the selected transfer mode. No real clock is switched: every clock is an enable pulse that lasts one system-clock cycle.

A horizontal-sync pulse starts each line. It restarts the line position counters and latches the whole line configuration. That configuration is the transfer mode, the active burst position and length, the gating enable, the gating start and stop positions, and the line-drop request. A dropped line keeps the valid flag low from start to end. When gating is on, the transfer-clock enable is removed during blanking outside a window bounded by the start and stop positions. The window is widened by four double-rate ticks on each side, so that header words can still be sent next to the burst.

Top module: `vop_clk_gate`

## Requirements
- R1: During reset and until the first `hsync_i` pulse after reset, every output is low.
- R2: `dbl_stb_o` pulses once every DIV system clocks. The first pulse comes in the cycle right after the clock edge that samples `hsync_i` high, and that pulse is double-rate tick index 0 of the line. Each later tick raises the index by one.
- R3: `pix_stb_o` pulses together with the double-rate ticks whose index is even, so there is one strobe per pixel period.
- R4: `word_stb_o` pulses only while `valid_o` is high, on these ticks, using the mode code captured at line start. Mode 0 (single) and mode 3 pulse on even-index ticks. Mode 1 (double) pulses on every double-rate tick. Mode 2 (half) pulses on ticks whose index is a multiple of 4.
- R5: The pixel position is the tick index divided by 2. `valid_o` is high across the whole pixel period of every position p with act_start ≤ p < act_start + act_len. This forms one unbroken burst of act_len pixels, and an act_len of 0 gives no burst.
- R6: `drop_i` is sampled at line start. When it is sampled high, `valid_o` and `word_stb_o` stay low for that entire line.
- R7: When the captured gating enable is 0, `xfer_en_o` equals `dbl_stb_o` on every cycle.
- R8: When the captured gating enable is 1, `xfer_en_o` pulses on a tick of index k only if max(0, 2·start − 4) ≤ k < 2·stop + 4. When stop lies well before start, the window is empty.
- R9: Changes to `drop_i` or to any configuration input during a line have no effect until the next `hsync_i` pulse.
- R10: `valid_o` does not depend on the gating enable or on the gating positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Line-start pulse, one system clock wide |
| drop_i | input | 1 | Request to suppress the next line |
| gate_en_i | input | 1 | Blanking clock gating enable |
| gate_start_i | input | PW | Gating window start, in pixels |
| gate_stop_i | input | PW | Gating window stop, in pixels |
| act_start_i | input | PW | First active pixel of the burst |
| act_len_i | input | PW | Burst length in pixels |
| mode_i | input | 2 | Transfer mode: 0 single, 1 double, 2 half, 3 as single |
| dbl_stb_o | output | 1 | Ungated double-rate tick |
| pix_stb_o | output | 1 | Pixel-rate strobe |
| xfer_en_o | output | 1 | Gated transfer-clock enable |
| word_stb_o | output | 1 | Data word transfer strobe |
| valid_o | output | 1 | Data-valid flag |

## Verification
The assertions check on every cycle the relations between the strobes. Every pixel and transfer strobe falls on a double-rate tick, and word strobes occur only inside valid. An ungated line copies the tick exactly, a dropped line stays silent, and valid changes only at a pixel boundary or a line start. Only the bench scenarios can show that the window bounds are correct. These include the clamp at position zero, an empty window, exact burst positions and lengths in each mode, and that configuration changed in the middle of a line is ignored. They are checked against expected values computed cycle by cycle.

// File: rtl/vop_pkg.sv
package vop_pkg;
  typedef enum logic [1:0] {
    XM_SINGLE = 2'd0,
    XM_DOUBLE = 2'd1,
    XM_HALF   = 2'd2,
    XM_RSVD   = 2'd3
  } xfer_mode_e;
endpackage

// File: rtl/vop_tick_gen.sv
module vop_tick_gen #(
  parameter int DIV = 2,
  parameter int CW  = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hsync_i,
  output logic          live_o,
  output logic          dbl_tick_o,
  output logic [CW-1:0] dbl_idx_o
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);
  localparam logic [CW-1:0] IDX_MAX  = '1;

  logic [DW-1:0] div_q;
  logic [CW-1:0] idx_q;
  logic          live_q;
  logic          period_end;

  assign period_end = (div_q == DIV_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      idx_q  <= '0;
      live_q <= 1'b0;
    end else if (hsync_i) begin
      div_q  <= '0;
      idx_q  <= '0;
      live_q <= 1'b1;
    end else begin
      div_q <= period_end ? '0 : div_q + 1'b1;
      // index advances at period end so it is constant across the period
      if (period_end && live_q && idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
    end
  end

  assign live_o     = live_q;
  assign dbl_tick_o = live_q && (div_q == '0);
  assign dbl_idx_o  = idx_q;
endmodule

// File: rtl/vop_line_cfg.sv
module vop_line_cfg
  import vop_pkg::*;
#(
  parameter int PW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hsync_i,
  input  logic          drop_i,
  input  logic          gate_en_i,
  input  logic [PW-1:0] gate_start_i,
  input  logic [PW-1:0] gate_stop_i,
  input  logic [PW-1:0] act_start_i,
  input  logic [PW-1:0] act_len_i,
  input  logic [1:0]    mode_i,
  output logic          drop_o,
  output logic          gate_en_o,
  output logic [PW-1:0] gate_start_o,
  output logic [PW-1:0] gate_stop_o,
  output logic [PW-1:0] act_start_o,
  output logic [PW-1:0] act_len_o,
  output xfer_mode_e    mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drop_o       <= 1'b0;
      gate_en_o    <= 1'b0;
      gate_start_o <= '0;
      gate_stop_o  <= '0;
      act_start_o  <= '0;
      act_len_o    <= '0;
      mode_o       <= XM_SINGLE;
    end else if (hsync_i) begin
      drop_o       <= drop_i;
      gate_en_o    <= gate_en_i;
      gate_start_o <= gate_start_i;
      gate_stop_o  <= gate_stop_i;
      act_start_o  <= act_start_i;
      act_len_o    <= act_len_i;
      mode_o       <= xfer_mode_e'(mode_i);
    end
  end
endmodule

// File: rtl/vop_gate_win.sv
module vop_gate_win #(
  parameter int PW     = 11,
  parameter int CW     = 12,
  parameter int MARGIN = 4
) (
  input  logic          gate_en_i,
  input  logic [PW-1:0] start_i,
  input  logic [PW-1:0] stop_i,
  input  logic          dbl_tick_i,
  input  logic [CW-1:0] dbl_idx_i,
  output logic          xfer_en_o
);
  localparam int LW = CW + 1;
  localparam logic [LW-1:0] MG = LW'(MARGIN);

  logic [LW-1:0] start2, lo, hi, idx_x;
  logic          in_win;

  always_comb begin
    start2 = {1'b0, start_i, 1'b0};
    lo     = (start2 > MG) ? start2 - MG : '0;
    hi     = {1'b0, stop_i, 1'b0} + MG;
    idx_x  = {1'b0, dbl_idx_i};
    in_win = (idx_x >= lo) && (idx_x < hi);
  end

  assign xfer_en_o = dbl_tick_i && (!gate_en_i || in_win);
endmodule

// File: rtl/vop_valid_gen.sv
module vop_valid_gen
  import vop_pkg::*;
#(
  parameter int PW = 11,
  parameter int CW = 12
) (
  input  logic          live_i,
  input  logic          drop_i,
  input  logic [PW-1:0] act_start_i,
  input  logic [PW-1:0] act_len_i,
  input  xfer_mode_e    mode_i,
  input  logic          dbl_tick_i,
  input  logic [CW-1:0] dbl_idx_i,
  output logic          valid_o,
  output logic          pix_stb_o,
  output logic          word_stb_o
);
  logic [PW-1:0] pix;
  logic [PW:0]   act_end;
  logic          in_burst;
  logic          mode_tick;

  always_comb begin
    pix      = dbl_idx_i[CW-1:1];
    act_end  = {1'b0, act_start_i} + {1'b0, act_len_i};
    in_burst = (pix >= act_start_i) && ({1'b0, pix} < act_end);
    unique case (mode_i)
      XM_DOUBLE: mode_tick = dbl_tick_i;
      XM_HALF:   mode_tick = dbl_tick_i && (dbl_idx_i[1:0] == 2'b00);
      default:   mode_tick = dbl_tick_i && !dbl_idx_i[0];
    endcase
  end

  assign valid_o    = live_i && !drop_i && in_burst;
  assign pix_stb_o  = dbl_tick_i && !dbl_idx_i[0];
  assign word_stb_o = valid_o && mode_tick;
endmodule

// File: rtl/vop_clk_gate.sv
module vop_clk_gate
  import vop_pkg::*;
#(
  parameter int DIV    = 2,
  parameter int PW     = 11,
  parameter int MARGIN = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hsync_i,
  input  logic          drop_i,
  input  logic          gate_en_i,
  input  logic [PW-1:0] gate_start_i,
  input  logic [PW-1:0] gate_stop_i,
  input  logic [PW-1:0] act_start_i,
  input  logic [PW-1:0] act_len_i,
  input  logic [1:0]    mode_i,
  output logic          dbl_stb_o,
  output logic          pix_stb_o,
  output logic          xfer_en_o,
  output logic          word_stb_o,
  output logic          valid_o
);
  localparam int CW = PW + 1;

  logic          live;
  logic          dbl_tick;
  logic [CW-1:0] dbl_idx;
  logic          cfg_drop, cfg_gate_en;
  logic [PW-1:0] cfg_gstart, cfg_gstop, cfg_astart, cfg_alen;
  xfer_mode_e    cfg_mode;

  vop_tick_gen #(.DIV(DIV), .CW(CW)) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hsync_i    (hsync_i),
    .live_o     (live),
    .dbl_tick_o (dbl_tick),
    .dbl_idx_o  (dbl_idx)
  );

  vop_line_cfg #(.PW(PW)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hsync_i      (hsync_i),
    .drop_i       (drop_i),
    .gate_en_i    (gate_en_i),
    .gate_start_i (gate_start_i),
    .gate_stop_i  (gate_stop_i),
    .act_start_i  (act_start_i),
    .act_len_i    (act_len_i),
    .mode_i       (mode_i),
    .drop_o       (cfg_drop),
    .gate_en_o    (cfg_gate_en),
    .gate_start_o (cfg_gstart),
    .gate_stop_o  (cfg_gstop),
    .act_start_o  (cfg_astart),
    .act_len_o    (cfg_alen),
    .mode_o       (cfg_mode)
  );

  vop_gate_win #(.PW(PW), .CW(CW), .MARGIN(MARGIN)) u_gate (
    .gate_en_i  (cfg_gate_en),
    .start_i    (cfg_gstart),
    .stop_i     (cfg_gstop),
    .dbl_tick_i (dbl_tick),
    .dbl_idx_i  (dbl_idx),
    .xfer_en_o  (xfer_en_o)
  );

  vop_valid_gen #(.PW(PW), .CW(CW)) u_valid (
    .live_i      (live),
    .drop_i      (cfg_drop),
    .act_start_i (cfg_astart),
    .act_len_i   (cfg_alen),
    .mode_i      (cfg_mode),
    .dbl_tick_i  (dbl_tick),
    .dbl_idx_i   (dbl_idx),
    .valid_o     (valid_o),
    .pix_stb_o   (pix_stb_o),
    .word_stb_o  (word_stb_o)
  );

  assign dbl_stb_o = dbl_tick;
endmodule

// File: rtl/vop_clk_gate_chk.sv
module vop_clk_gate_chk #(
  parameter int DIV = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic hsync_i,
  input logic cfg_drop,
  input logic cfg_gate_en,
  input logic dbl_stb_o,
  input logic pix_stb_o,
  input logic xfer_en_o,
  input logic word_stb_o,
  input logic valid_o
);
  a_r2_dbl_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DIV > 1) && dbl_stb_o && !hsync_i |=> !dbl_stb_o);

  a_r3_pix_on_dbl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_stb_o |-> dbl_stb_o);

  a_r4_word_in_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_stb_o |-> valid_o && dbl_stb_o);

  a_r5_valid_at_pix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(valid_o) |-> pix_stb_o || $past(hsync_i));

  a_r6_drop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_drop |-> !valid_o && !word_stb_o);

  a_r7_ungated_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_gate_en |-> xfer_en_o == dbl_stb_o);

  a_r8_xfer_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_en_o |-> dbl_stb_o);
endmodule

bind vop_clk_gate vop_clk_gate_chk #(.DIV(DIV)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hsync_i     (hsync_i),
  .cfg_drop    (cfg_drop),
  .cfg_gate_en (cfg_gate_en),
  .dbl_stb_o   (dbl_stb_o),
  .pix_stb_o   (pix_stb_o),
  .xfer_en_o   (xfer_en_o),
  .word_stb_o  (word_stb_o),
  .valid_o     (valid_o)
);

// File: tb/tb_vop_clk_gate.sv
`timescale 1ns/1ps
module tb_vop_clk_gate;
  localparam int DIV = 2;
  localparam int PW  = 11;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic hsync_i = 1'b0, drop_i = 1'b0, gate_en_i = 1'b0;
  logic [PW-1:0] gate_start_i = '0, gate_stop_i = '0, act_start_i = '0, act_len_i = '0;
  logic [1:0] mode_i = 2'd0;
  logic dbl_stb_o, pix_stb_o, xfer_en_o, word_stb_o, valid_o;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk_i = ~clk_i;

  vop_clk_gate #(.DIV(DIV), .PW(PW), .MARGIN(4)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .hsync_i(hsync_i), .drop_i(drop_i),
    .gate_en_i(gate_en_i), .gate_start_i(gate_start_i), .gate_stop_i(gate_stop_i),
    .act_start_i(act_start_i), .act_len_i(act_len_i), .mode_i(mode_i),
    .dbl_stb_o(dbl_stb_o), .pix_stb_o(pix_stb_o), .xfer_en_o(xfer_en_o),
    .word_stb_o(word_stb_o), .valid_o(valid_o)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  function automatic bit exp_valid(int k, bit dr, int as, int al);
    int p = k / 2;
    return !dr && p >= as && p < as + al;
  endfunction

  function automatic bit exp_word(int k, bit tick, bit v, int md);
    if (!v || !tick) return 0;
    if (md == 1) return 1;
    if (md == 2) return (k % 4) == 0;
    return (k % 2) == 0;
  endfunction

  function automatic bit exp_xfer(int k, bit tick, bit ge, int gs, int gp);
    int lo = (2 * gs > 4) ? 2 * gs - 4 : 0;
    int hi = 2 * gp + 4;
    return tick && (!ge || (k >= lo && k < hi));
  endfunction

  task automatic check_idle(input string tag);
    chk(dbl_stb_o, 1'b0, {tag, " dbl"});
    chk(pix_stb_o, 1'b0, {tag, " pix"});
    chk(xfer_en_o, 1'b0, {tag, " xfer"});
    chk(word_stb_o, 1'b0, {tag, " word"});
    chk(valid_o, 1'b0, {tag, " valid"});
  endtask

  // called at a negedge; leaves at a negedge
  task automatic run_line(input int ncyc, input bit ge, input int gs, input int gp,
                          input int as, input int al, input int md, input bit dr);
    hsync_i = 1'b1; drop_i = dr; gate_en_i = ge; mode_i = 2'(md);
    gate_start_i = PW'(gs); gate_stop_i = PW'(gp);
    act_start_i = PW'(as); act_len_i = PW'(al);
    @(negedge clk_i);
    hsync_i = 1'b0;
    for (int n = 1; n <= ncyc; n++) begin
      int  k    = (n - 1) / DIV;
      bit  tick = ((n - 1) % DIV) == 0;
      bit  v    = exp_valid(k, dr, as, al);
      chk(dbl_stb_o, tick, "R2 dbl tick");
      chk(pix_stb_o, tick && (k % 2 == 0), "R3 pix strobe");
      chk(valid_o, v, dr ? "R6 drop valid" : "R5 R10 valid burst");
      chk(word_stb_o, exp_word(k, tick, v, md), dr ? "R6 drop word" : "R4 word mode");
      chk(xfer_en_o, exp_xfer(k, tick, ge, gs, gp), ge ? "R8 gated xfer" : "R7 ungated xfer");
      if (n == 10) begin
        // R9: mid-line changes must be ignored
        drop_i = ~dr; gate_en_i = ~ge; mode_i = 2'($urandom_range(0, 3));
        gate_start_i = PW'($urandom_range(0, 127)); gate_stop_i = PW'($urandom_range(0, 127));
        act_start_i = PW'($urandom_range(0, 127)); act_len_i = PW'($urandom_range(0, 127));
      end
      @(negedge clk_i);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c1c));
    repeat (3) @(negedge clk_i);
    check_idle("R1 in reset");
    rst_ni = 1'b1;
    repeat (20) begin
      @(negedge clk_i);
      check_idle("R1 before hsync");
    end
    // directed corners
    run_line(120, 1'b0, 0, 0, 5, 16, 1, 1'b0);
    run_line(120, 1'b1, 0, 10, 2, 6, 2, 1'b0);
    run_line(120, 1'b1, 1, 3, 0, 4, 0, 1'b0);
    run_line(120, 1'b1, 30, 10, 3, 20, 1, 1'b0);
    run_line(120, 1'b1, 5, 40, 3, 20, 1, 1'b1);
    run_line(120, 1'b0, 0, 0, 7, 9, 3, 1'b0);
    run_line(120, 1'b1, 4, 20, 10, 0, 1, 1'b0);
    // random lines
    for (int i = 0; i < 40; i++) begin
      run_line($urandom_range(60, 500), 1'($urandom_range(0, 1)),
               $urandom_range(0, 127), $urandom_range(0, 127),
               $urandom_range(0, 127), $urandom_range(0, 127),
               $urandom_range(0, 3), ($urandom_range(0, 5) == 0));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule